// File: doc/BRIEF.md
# MDIO Management Master With Presence Check

This block runs MDIO management frames (Clause 22 framing) for the logic around it. A request gives a 10-bit register index, a read/write flag and 16 bits of write data. The upper five index bits become the address field and the lower five become the register field. The block produces MDC at a half-period of `HALF_DIV` system clocks and drives or releases the shared data line through an output value and an output enable. The line's level comes back on `mdio_in`. When a frame ends, the block raises a one-cycle completion strobe and holds the read data and an absent-target flag.

A read frame watches the turnaround. If the second turnaround bit is not pulled low, no target is assumed to be there. The block then runs 32 recovery clocks on the released line and reports `16'hFFFF` with the absent flag set. Some registers are slow to read, namely any index of `0x300` or above. For these, the block runs two complete read frames back to back, discards the first result and reports only the second. Writes are never repeated.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset and between frames, `cmd_ready` is 1, `mdc` is 0 and `mdio_oe` is 0. A request is taken only on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_valid` has no effect while a frame is running: no extra frame is sent and the running frame's fields do not change.
- R2: MDC stays high for `HALF_DIV` system clocks and low for `HALF_DIV` system clocks. Each bit slot is one low half followed by one high half. While the master drives the line, the driven value changes only on the clock edge where MDC falls.
- R3: Every frame starts with 32 slots driven high. Next come the start bits 0 then 1 and the opcode (`10` read, `01` write). Then come the address field `cmd_index[9:5]` and the register field `cmd_index[4:0]`, each sent MSB first. The line is driven throughout this part.
- R4: In a read, the master releases the line for the two turnaround slots. It samples the line at the end of the high half of the second slot. It then samples 16 data bits MSB first at the end of each high half and adds two trailing slots. A read with a target present lasts 66 MDC cycles.
- R5: If the sampled turnaround bit is 1, the master keeps the line released for 32 more slots. It then completes with `rsp_rdata` = `16'hFFFF` and `rsp_absent` = 1. This frame lasts 80 MDC cycles.
- R6: In a write, the master drives the turnaround bits 1 then 0 and then `cmd_wdata` MSB first. It releases the line for one final slot. A write frame lasts 65 MDC cycles.
- R7: A read whose index is `0x300` or above runs two complete read frames back to back and reports only the second result. A read of `0x2FF` runs one frame. A write to any index runs one frame.
- R8: `rsp_done` is high for exactly one cycle per request. `rsp_rdata` and `rsp_absent` are valid in that cycle and held until the next completion. `rsp_absent` is 0 after a present read or after a write, and a write leaves `rsp_rdata` unchanged. A request presented in the same cycle as `rsp_done` is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Block idle, request can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_index | input | 10 | Register index: address field [9:5], register field [4:0] |
| cmd_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 16 | Read result, held between completions |
| rsp_absent | output | 1 | Turnaround was not driven low on the last read |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | 1 = master drives the data line |
| mdio_in | input | 1 | Level seen on the data line |

## Verification
The completion strobe and the acceptance of the next request can fall in the same cycle, because the block is already idle when `rsp_done` is high. The bench provokes this by presenting a second read on the exact cycle it sees the strobe of the first read. It then expects `cmd_ready` to drop one cycle later with the strobe already gone. It also expects the second result to match the target model. Recovery and dummy-read restart can also coincide, in a slow-index read to an absent target. The bench judges that case by counting two 80-cycle frames.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TURN,
        ST_DATA,
        ST_TAIL,
        ST_RECOV
    } frame_state_e;

    localparam logic [1:0] START_CODE = 2'b01;
    localparam logic [1:0] OPC_READ   = 2'b10;
    localparam logic [1:0] OPC_WRITE  = 2'b01;

endpackage

// File: rtl/mdc_phase_gen.sv
module mdc_phase_gen #(
    parameter int HALF_DIV = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic slot_end
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ph;
    } phase_t;

    phase_t ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        if (!run) begin
            ph_d = '0;
        end else if (ph_q.cnt == LAST) begin
            ph_d.cnt = '0;
            ph_d.ph  = ~ph_q.ph;
        end else begin
            ph_d.cnt = ph_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign mdc      = ph_q.ph;
    assign slot_end = run && ph_q.ph && (ph_q.cnt == LAST);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
#(
    parameter int IDX_W     = 10,
    parameter int DATA_W    = 16,
    parameter int PRE_LEN   = 32,
    parameter int RECOV_LEN = 32,
    parameter int SLOW_BASE = 768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_end,
    input  logic              mdio_in,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_ready,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_absent
);
    localparam int HDR_W  = 4 + IDX_W;
    localparam int MAX_A  = (PRE_LEN > RECOV_LEN) ? PRE_LEN : RECOV_LEN;
    localparam int MAX_B  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
    localparam int MAXLEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW     = $clog2(MAXLEN + 1);

    typedef struct packed {
        frame_state_e      st;
        logic [CW-1:0]     cnt;
        logic [HDR_W-1:0]  hdr;
        logic [HDR_W-1:0]  hdr0;
        logic [DATA_W-1:0] shreg;
        logic              wr;
        logic              dummy;
        logic              oe;
        logic              dout;
        logic              done;
        logic [DATA_W-1:0] rdata;
        logic              absent;
    } seq_t;

    seq_t s_d, s_q;
    logic fin;
    logic fin_abs;

    always_comb begin
        s_d     = s_q;
        s_d.done = 1'b0;
        fin     = 1'b0;
        fin_abs = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    s_d.st    = ST_PRE;
                    s_d.cnt   = '0;
                    s_d.oe    = 1'b1;
                    s_d.dout  = 1'b1;
                    s_d.wr    = cmd_write;
                    s_d.hdr   = {START_CODE, (cmd_write ? OPC_WRITE : OPC_READ), cmd_index};
                    s_d.hdr0  = {START_CODE, (cmd_write ? OPC_WRITE : OPC_READ), cmd_index};
                    s_d.shreg = cmd_wdata;
                    s_d.dummy = !cmd_write && (cmd_index >= IDX_W'(SLOW_BASE));
                end
            end
            ST_PRE: if (slot_end) begin
                if (s_q.cnt == CW'(PRE_LEN - 1)) begin
                    s_d.st   = ST_HDR;
                    s_d.cnt  = '0;
                    s_d.dout = s_q.hdr[HDR_W-1];
                    s_d.hdr  = {s_q.hdr[HDR_W-2:0], 1'b0};
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_HDR: if (slot_end) begin
                if (s_q.cnt == CW'(HDR_W - 1)) begin
                    s_d.st   = ST_TURN;
                    s_d.cnt  = '0;
                    s_d.oe   = s_q.wr;
                    s_d.dout = 1'b1;
                end else begin
                    s_d.cnt  = s_q.cnt + 1'b1;
                    s_d.dout = s_q.hdr[HDR_W-1];
                    s_d.hdr  = {s_q.hdr[HDR_W-2:0], 1'b0};
                end
            end
            ST_TURN: if (slot_end) begin
                if (s_q.cnt == '0) begin
                    s_d.cnt  = 1;
                    s_d.dout = 1'b0;
                end else begin
                    s_d.cnt = '0;
                    if (s_q.wr) begin
                        s_d.st    = ST_DATA;
                        s_d.dout  = s_q.shreg[DATA_W-1];
                        s_d.shreg = {s_q.shreg[DATA_W-2:0], 1'b0};
                    end else if (mdio_in) begin
                        s_d.st = ST_RECOV;
                    end else begin
                        s_d.st = ST_DATA;
                    end
                end
            end
            ST_DATA: if (slot_end) begin
                if (s_q.wr) begin
                    s_d.dout  = s_q.shreg[DATA_W-1];
                    s_d.shreg = {s_q.shreg[DATA_W-2:0], 1'b0};
                end else begin
                    s_d.shreg = {s_q.shreg[DATA_W-2:0], mdio_in};
                end
                if (s_q.cnt == CW'(DATA_W - 1)) begin
                    s_d.st  = ST_TAIL;
                    s_d.cnt = '0;
                    s_d.oe  = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_TAIL: if (slot_end) begin
                if (s_q.cnt == (s_q.wr ? CW'(0) : CW'(1))) fin = 1'b1;
                else                                       s_d.cnt = s_q.cnt + 1'b1;
            end
            ST_RECOV: if (slot_end) begin
                if (s_q.cnt == CW'(RECOV_LEN - 1)) begin
                    fin     = 1'b1;
                    fin_abs = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (fin) begin
            if (s_q.dummy) begin
                s_d.dummy = 1'b0;
                s_d.st    = ST_PRE;
                s_d.cnt   = '0;
                s_d.oe    = 1'b1;
                s_d.dout  = 1'b1;
                s_d.hdr   = s_q.hdr0;
            end else begin
                s_d.st     = ST_IDLE;
                s_d.done   = 1'b1;
                s_d.absent = fin_abs;
                if (!s_q.wr) s_d.rdata = fin_abs ? '1 : s_q.shreg;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_ready  = (s_q.st == ST_IDLE);
    assign mdio_out   = s_q.dout;
    assign mdio_oe    = s_q.oe;
    assign rsp_done   = s_q.done;
    assign rsp_rdata  = s_q.rdata;
    assign rsp_absent = s_q.absent;

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
    parameter int HALF_DIV  = 500,
    parameter int IDX_W     = 10,
    parameter int DATA_W    = 16,
    parameter int PRE_LEN   = 32,
    parameter int RECOV_LEN = 32,
    parameter int SLOW_BASE = 768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_absent,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);
    logic slot_end;

    mdc_phase_gen #(
        .HALF_DIV(HALF_DIV)
    ) phase_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (~cmd_ready),
        .mdc      (mdc),
        .slot_end (slot_end)
    );

    mdio_frame_seq #(
        .IDX_W     (IDX_W),
        .DATA_W    (DATA_W),
        .PRE_LEN   (PRE_LEN),
        .RECOV_LEN (RECOV_LEN),
        .SLOW_BASE (SLOW_BASE)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_end   (slot_end),
        .mdio_in    (mdio_in),
        .cmd_valid  (cmd_valid),
        .cmd_write  (cmd_write),
        .cmd_index  (cmd_index),
        .cmd_wdata  (cmd_wdata),
        .cmd_ready  (cmd_ready),
        .mdio_out   (mdio_out),
        .mdio_oe    (mdio_oe),
        .rsp_done   (rsp_done),
        .rsp_rdata  (rsp_rdata),
        .rsp_absent (rsp_absent)
    );

endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              mdc,
    input logic              mdio_out,
    input logic              mdio_oe,
    input logic              rsp_done,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_absent
);
    // R1: idle means clock parked low and line released
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!mdio_oe && !mdc));

    // R1: a taken request makes the block busy on the next cycle
    a_r1_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R2: driven value moves only where MDC falls
    a_r2_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && !$stable(mdio_out)) |-> $fell(mdc));

    // R5: absent flag always comes with all-ones data
    a_r5_absent_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_absent |-> (rsp_rdata == {DATA_W{1'b1}}));

    // R8: completion strobe lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R8: completion only while idle
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> cmd_ready);

    // R8: result held between completions
    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rsp_rdata) || !$stable(rsp_absent)) |-> rsp_done);

endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(
    .DATA_W(DATA_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .mdc        (mdc),
    .mdio_out   (mdio_out),
    .mdio_oe    (mdio_oe),
    .rsp_done   (rsp_done),
    .rsp_rdata  (rsp_rdata),
    .rsp_absent (rsp_absent)
);

// File: tb/mdio_mgmt_master_tb_top.sv
module mdio_mgmt_master_tb_top;
    localparam int HALF = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_write = 1'b0;
    logic [9:0]  cmd_index = '0;
    logic [15:0] cmd_wdata = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        rsp_absent;
    logic        mdc;
    logic        mdio_out;
    logic        mdio_oe;
    logic        mdio_in;

    mdio_mgmt_master #(.HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_index(cmd_index), .cmd_wdata(cmd_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_absent(rsp_absent),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    int errs = 0;
    int nchk = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mval(input logic [9:0] i);
        return {i[5:0], i} ^ 16'hC35A;
    endfunction

    // ---------------- target model ----------------
    int          pos = 0;
    int          rises = 0;
    int          frames = 0;
    int          pre_err = 0;
    int          hdr_err = 0;
    int          flen;
    logic        present = 1'b1;
    logic        in_r = 1'b1;
    logic        drv;
    logic        isrd;
    logic        prev_valid = 1'b0;
    logic [9:0]  prev_idx = '0;
    logic [13:0] m_hdr = '0, last_hdr = '0;
    logic [1:0]  m_ta = '0, m_ta_oe = '0, last_ta = '0, last_ta_oe = '0;
    logic [15:0] m_wd = '0, last_wd = '0, m_val = '0;
    logic        m_rel = 1'b0, last_rel = 1'b0;

    assign mdio_in = in_r;

    always @(posedge mdc) begin
        drv = mdio_oe ? mdio_out : 1'b1;
        rises++;
        if (pos < 32) begin
            if (!(mdio_oe && mdio_out)) pre_err++;
        end else if (pos < 46) begin
            m_hdr = {m_hdr[12:0], drv};
            if (!mdio_oe) hdr_err++;
        end else if (pos < 48) begin
            m_ta    = {m_ta[0], drv};
            m_ta_oe = {m_ta_oe[0], mdio_oe};
        end else if (pos < 64) begin
            m_wd = {m_wd[14:0], drv};
        end else if (pos == 64) begin
            m_rel = mdio_oe;
        end
        isrd = (m_hdr[11:10] == 2'b10);
        if (pos == 45) begin
            m_val = mval(m_hdr[9:0]);
            if (m_hdr[9:0] >= 10'h300 && !(prev_valid && prev_idx == m_hdr[9:0]))
                m_val = ~m_val;
        end
        in_r = 1'b1;
        if (present && isrd && pos == 47) in_r = 1'b0;
        else if (present && isrd && pos >= 48 && pos < 64) in_r = m_val[63-pos];
        pos++;
        flen = !isrd ? 65 : (present ? 66 : 80);
        if (pos >= 46 && pos == flen) begin
            pos = 0;
            frames++;
            last_hdr   = m_hdr;
            last_ta    = m_ta;
            last_ta_oe = m_ta_oe;
            last_wd    = m_wd;
            last_rel   = m_rel;
            prev_valid = isrd;
            prev_idx   = m_hdr[9:0];
            in_r       = 1'b1;
        end
    end

    // ---------------- helpers ----------------
    task automatic issue(input logic wr, input logic [9:0] idx, input logic [15:0] wd);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_index = idx; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(output logic [15:0] rd, output logic ab);
        int n = 0;
        while (!rsp_done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (!rsp_done) check("R8 completion timeout", 0, 1);
        rd = rsp_rdata;
        ab = rsp_absent;
    endtask

    task automatic do_cmd(input logic wr, input logic [9:0] idx, input logic [15:0] wd,
                          output logic [15:0] rd, output logic ab, output int nr, output int nf);
        int r0 = rises;
        int f0 = frames;
        issue(wr, idx, wd);
        wait_done(rd, ab);
        nr = rises - r0;
        nf = frames - f0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        check("R1 reset cmd_ready", cmd_ready, 1);
        check("R1 reset mdc low", mdc, 0);
        check("R1 reset line released", mdio_oe, 0);
        check("R8 reset done low", rsp_done, 0);
    endtask

    task automatic t_half_period();
        logic [15:0] rd; logic ab; int nh = 0; int nl = 0;
        issue(1'b0, 10'h041, 16'h0);
        while (!mdc) @(negedge clk);
        while (mdc) begin nh++; @(negedge clk); end
        while (!mdc) begin nl++; @(negedge clk); end
        check("R2 mdc high clocks", nh, HALF);
        check("R2 mdc low clocks", nl, HALF);
        wait_done(rd, ab);
        check("R4 read data 0x041", rd, mval(10'h041));
    endtask

    task automatic t_read_basic();
        logic [15:0] rd; logic ab; int nr, nf; int pe = pre_err; int he = hdr_err;
        do_cmd(1'b0, 10'h0A7, 16'h0, rd, ab, nr, nf);
        @(negedge clk);
        check("R8 done single cycle", rsp_done, 0);
        check("R8 rdata held", rsp_rdata, mval(10'h0A7));
        check("R4 read data", rd, mval(10'h0A7));
        check("R8 absent clear on present read", ab, 0);
        check("R4 read frame length", nr, 66);
        check("R3 preamble driven high", pre_err - pe, 0);
        check("R3 header driven", hdr_err - he, 0);
        check("R3 read header", last_hdr, {2'b01, 2'b10, 10'h0A7});
        check("R4 turnaround released", last_ta_oe, 2'b00);
    endtask

    task automatic t_write();
        logic [15:0] rd; logic ab; int nr, nf;
        do_cmd(1'b1, 10'h15C, 16'hBEEF, rd, ab, nr, nf);
        check("R3 write header", last_hdr, {2'b01, 2'b01, 10'h15C});
        check("R6 write turnaround bits", last_ta, 2'b10);
        check("R6 write turnaround driven", last_ta_oe, 2'b11);
        check("R6 write data", last_wd, 16'hBEEF);
        check("R6 final slot released", last_rel, 0);
        check("R6 write frame length", nr, 65);
        check("R8 write leaves rdata", rd, mval(10'h0A7));
        check("R8 write absent clear", ab, 0);
    endtask

    task automatic t_slow();
        logic [15:0] rd; logic ab; int nr, nf;
        do_cmd(1'b0, 10'h2FF, 16'h0, rd, ab, nr, nf);
        check("R7 0x2FF single frame", nf, 1);
        check("R7 0x2FF data", rd, mval(10'h2FF));
        do_cmd(1'b0, 10'h300, 16'h0, rd, ab, nr, nf);
        check("R7 0x300 two frames", nf, 2);
        check("R7 0x300 length", nr, 132);
        check("R7 0x300 second result", rd, mval(10'h300));
        do_cmd(1'b0, 10'h3FF, 16'h0, rd, ab, nr, nf);
        check("R7 0x3FF second result", rd, mval(10'h3FF));
        check("R7 0x3FF two frames", nf, 2);
        do_cmd(1'b1, 10'h3A5, 16'h1234, rd, ab, nr, nf);
        check("R7 slow write single frame", nf, 1);
        check("R7 slow write data", last_wd, 16'h1234);
    endtask

    task automatic t_absent();
        logic [15:0] rd; logic ab; int nr, nf;
        present = 1'b0;
        do_cmd(1'b0, 10'h012, 16'h0, rd, ab, nr, nf);
        check("R5 absent data", rd, 16'hFFFF);
        check("R5 absent flag", ab, 1);
        check("R5 absent frame length", nr, 80);
        do_cmd(1'b0, 10'h310, 16'h0, rd, ab, nr, nf);
        check("R5 slow absent two frames", nf, 2);
        check("R5 slow absent length", nr, 160);
        check("R5 slow absent flag", ab, 1);
        present = 1'b1;
        do_cmd(1'b0, 10'h013, 16'h0, rd, ab, nr, nf);
        check("R8 absent cleared", ab, 0);
        check("R4 data after absent", rd, mval(10'h013));
    endtask

    task automatic t_busy_ignored();
        logic [15:0] rd; logic ab; int f0 = frames;
        issue(1'b1, 10'h123, 16'h1357);
        repeat (40) @(negedge clk);
        check("R1 busy not ready", cmd_ready, 0);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_index = 10'h2AA; cmd_wdata = 16'hFFFF;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done(rd, ab);
        repeat (4 * HALF) @(negedge clk);
        check("R1 busy request no frame", frames - f0, 1);
        check("R1 busy request no effect idx", last_hdr, {2'b01, 2'b01, 10'h123});
        check("R1 busy request no effect data", last_wd, 16'h1357);
    endtask

    task automatic t_back_to_back();
        logic [15:0] rd; logic ab;
        issue(1'b0, 10'h055, 16'h0);
        wait_done(rd, ab);
        check("R8 first of pair", rd, mval(10'h055));
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_index = 10'h066;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R8 taken in done cycle", cmd_ready, 0);
        check("R8 strobe gone", rsp_done, 0);
        wait_done(rd, ab);
        check("R8 second of pair", rd, mval(10'h066));
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, nchk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        nchk++;
        $display("FAIL watchdog (R1-wide hang): actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_half_period();
        t_read_basic();
        t_write();
        t_slow();
        t_absent();
        t_busy_ignored();
        t_back_to_back();
        summary();
        $finish;
    end

endmodule